// File: doc/BRIEF.md
# Paged Program Sequencer with One-Level Return Register

This block produces the instruction fetch address for a small controller whose program store holds 2K single-word instructions. An 11-bit program counter advances by one each time the instruction-complete strobe is seen. The counter can also be reloaded by a jump, a call or a return that the decoder has already identified.

A branch target has two parts. The upper four bits come from a bank register that software loads beforehand through a write-only port. The lower seven bits come from the offset carried with the branch. Together they pick a location in one of sixteen 128-word blocks.

A call saves the address that follows the call into a single return register. A return loads the counter from that register. Only one call level exists. A call made while a call is already open raises a sticky error flag and leaves the saved address as it was.

All pins are plain level-sensitive control and status signals. There is no valid/ready handshake. The block never stalls, and a request only takes effect in a cycle where the instruction-complete strobe is high.

Top module: `pgm_seq`

## Requirements
- R1: After reset, `fetch_addr` is 0 and `nest_err` is 0. The bank register and return register are also cleared to 0.
- R2: In a cycle with `step`=1 and no jump, call or return request, `fetch_addr` increases by exactly 1 at the next clock edge.
- R3: Incrementing from address 0x7FF gives 0x000.
- R4: When `step`=0, `fetch_addr` keeps its value and any jump, call or return request is ignored.
- R5: A jump taken with `step`=1 loads `fetch_addr` with {bank, `tgt_ofs`}. The bank occupies bits 10:7 and the offset occupies bits 6:0. The bank value used is the one held before that clock edge, so a bank write in the same cycle affects only later branches.
- R6: A bank write (`bank_we`=1, data on `bank_wdata`) does not change `fetch_addr` by itself.
- R7: A call taken with `step`=1 while no call is open does three things: it loads `fetch_addr` with {bank, `tgt_ofs`}, saves the call's own address plus 1, and marks a call as open.
- R8: A return taken with `step`=1 loads `fetch_addr` with the saved address and closes the open call, so a later call is legal again.
- R9: A call taken while a call is already open still branches to {bank, `tgt_ofs`}. It sets `nest_err`, which stays 1 until reset, and it leaves the saved return address unchanged.
- R10: When several requests arrive together with `step`=1, return wins over call and call wins over jump.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 1 | Current instruction completes this cycle |
| jmp_req | input | 1 | Decoded jump |
| call_req | input | 1 | Decoded subroutine call |
| ret_req | input | 1 | Decoded return |
| tgt_ofs | input | 7 | In-block branch offset |
| bank_we | input | 1 | Bank register write enable |
| bank_wdata | input | 4 | Bank register write data |
| fetch_addr | output | 11 | Address of the next instruction to fetch |
| nest_err | output | 1 | Sticky nested-call error |

## Verification
The bench uses several stimulus patterns, each aimed at a different part of the next-address logic:

- Plain stepping tells increment apart from hold.
- Requests made with `step` low confirm that nothing is taken without the strobe.
- A bank write made in the same cycle as a call separates old-bank from new-bank target formation.
- A call/return pair followed by a nested call shows whether the open-call flag is cleared on return and whether a second call protects the saved address.
- Combined jump+call+return requests fix the priority order.
- A jump to 0x7FF followed by a step exposes the wrap.
- A mid-run reset confirms that the sticky flag clears.

// File: rtl/pgm_seq_pkg.sv
package pgm_seq_pkg;
  typedef enum logic [1:0] {
    NXT_HOLD = 2'd0,
    NXT_INC  = 2'd1,
    NXT_TGT  = 2'd2,
    NXT_RET  = 2'd3
  } nxt_sel_e;
endpackage

// File: rtl/pgm_seq_bank.sv
module pgm_seq_bank #(
  parameter int BANK_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [BANK_W-1:0] wdata,
  output logic [BANK_W-1:0] bank
);
  always_ff @(posedge clk) begin
    if (!rst_n)  bank <= '0;
    else if (we) bank <= wdata;
  end
endmodule

// File: rtl/pgm_seq_stack.sv
module pgm_seq_stack #(
  parameter int PC_W = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            do_call,
  input  logic            do_ret,
  input  logic [PC_W-1:0] save_addr,
  output logic [PC_W-1:0] ret_addr,
  output logic            nest_err
);
  logic open_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ret_addr <= '0;
      open_q   <= 1'b0;
      nest_err <= 1'b0;
    end else if (do_ret) begin
      open_q <= 1'b0;
    end else if (do_call) begin
      if (open_q) begin
        nest_err <= 1'b1;
      end else begin
        ret_addr <= save_addr;
        open_q   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pgm_seq_pc.sv
module pgm_seq_pc
  import pgm_seq_pkg::*;
#(
  parameter int PC_W = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  nxt_sel_e        sel,
  input  logic [PC_W-1:0] tgt,
  input  logic [PC_W-1:0] ret_addr,
  output logic [PC_W-1:0] pc,
  output logic [PC_W-1:0] pc_inc
);
  assign pc_inc = pc + PC_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) pc <= '0;
    else begin
      unique case (sel)
        NXT_INC: pc <= pc_inc;
        NXT_TGT: pc <= tgt;
        NXT_RET: pc <= ret_addr;
        default: pc <= pc;
      endcase
    end
  end
endmodule

// File: rtl/pgm_seq.sv
module pgm_seq
  import pgm_seq_pkg::*;
#(
  parameter int PC_W  = 11,
  parameter int OFS_W = 7,
  localparam int BANK_W = PC_W - OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              jmp_req,
  input  logic              call_req,
  input  logic              ret_req,
  input  logic [OFS_W-1:0]  tgt_ofs,
  input  logic              bank_we,
  input  logic [BANK_W-1:0] bank_wdata,
  output logic [PC_W-1:0]   fetch_addr,
  output logic              nest_err
);
  logic [BANK_W-1:0] bank_q;
  logic [PC_W-1:0]   ret_addr;
  logic [PC_W-1:0]   pc_inc;
  logic              do_ret, do_call, do_jmp;
  nxt_sel_e          sel;

  // return > call > jump, all gated by the completion strobe
  assign do_ret  = step & ret_req;
  assign do_call = step & call_req & ~ret_req;
  assign do_jmp  = step & jmp_req & ~call_req & ~ret_req;

  always_comb begin
    if (!step)                 sel = NXT_HOLD;
    else if (do_ret)           sel = NXT_RET;
    else if (do_call | do_jmp) sel = NXT_TGT;
    else                       sel = NXT_INC;
  end

  pgm_seq_bank #(.BANK_W(BANK_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(bank_we), .wdata(bank_wdata), .bank(bank_q)
  );

  pgm_seq_stack #(.PC_W(PC_W)) u_stack (
    .clk(clk), .rst_n(rst_n), .do_call(do_call), .do_ret(do_ret),
    .save_addr(pc_inc), .ret_addr(ret_addr), .nest_err(nest_err)
  );

  pgm_seq_pc #(.PC_W(PC_W)) u_pc (
    .clk(clk), .rst_n(rst_n), .sel(sel), .tgt({bank_q, tgt_ofs}),
    .ret_addr(ret_addr), .pc(fetch_addr), .pc_inc(pc_inc)
  );
endmodule

// File: rtl/pgm_seq_chk.sv
module pgm_seq_chk #(
  parameter int PC_W  = 11,
  parameter int OFS_W = 7,
  parameter int BANK_W = PC_W - OFS_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              step,
  input logic              jmp_req,
  input logic              call_req,
  input logic              ret_req,
  input logic [OFS_W-1:0]  tgt_ofs,
  input logic [BANK_W-1:0] bank_q,
  input logic [PC_W-1:0]   ret_addr,
  input logic [PC_W-1:0]   fetch_addr,
  input logic              nest_err
);
  AST_STEP_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !jmp_req && !call_req && !ret_req) |=>
      (fetch_addr == PC_W'($past(fetch_addr) + 1'b1))); // R2

  AST_NO_STEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(fetch_addr)); // R4

  AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (step && jmp_req && !call_req && !ret_req) |=>
      (fetch_addr == {$past(bank_q), $past(tgt_ofs)})); // R5

  AST_RET_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (step && ret_req) |=> (fetch_addr == $past(ret_addr))); // R8

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    nest_err |=> nest_err); // R9

  AST_ERR_KEEPS_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
    (nest_err && !$past(nest_err)) |-> $stable(ret_addr)); // R9
endmodule

bind pgm_seq pgm_seq_chk #(.PC_W(PC_W), .OFS_W(OFS_W), .BANK_W(BANK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .step(step), .jmp_req(jmp_req), .call_req(call_req),
  .ret_req(ret_req), .tgt_ofs(tgt_ofs), .bank_q(bank_q), .ret_addr(ret_addr),
  .fetch_addr(fetch_addr), .nest_err(nest_err)
);

// File: tb/pgm_seq_tb_top.sv
module pgm_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step = 1'b0, jmp_req = 1'b0, call_req = 1'b0, ret_req = 1'b0;
  logic [6:0]  tgt_ofs = '0;
  logic        bank_we = 1'b0;
  logic [3:0]  bank_wdata = '0;
  logic [10:0] fetch_addr;
  logic        nest_err;
  int          n_vec = 0, n_bad = 0;

  always #4 clk = ~clk;

  pgm_seq dut_i (
    .clk(clk), .rst_n(rst_n), .step(step), .jmp_req(jmp_req), .call_req(call_req),
    .ret_req(ret_req), .tgt_ofs(tgt_ofs), .bank_we(bank_we), .bank_wdata(bank_wdata),
    .fetch_addr(fetch_addr), .nest_err(nest_err)
  );

  // {req[3:0], step, jmp, call, ret, ofs[6:0], bwe, bdata[3:0], exp_addr[10:0], exp_err}
  localparam int NV = 18;
  localparam logic [31:0] VECS [NV] = '{
    {4'd2,  4'b1000, 7'h00, 1'b0, 4'h0, 11'h001, 1'b0}, // R2
    {4'd2,  4'b1000, 7'h00, 1'b0, 4'h0, 11'h002, 1'b0}, // R2
    {4'd4,  4'b0111, 7'h05, 1'b0, 4'h0, 11'h002, 1'b0}, // R4 requests without step
    {4'd6,  4'b0000, 7'h00, 1'b1, 4'h3, 11'h002, 1'b0}, // R6 bank write only
    {4'd5,  4'b1100, 7'h10, 1'b0, 4'h0, 11'h190, 1'b0}, // R5
    {4'd2,  4'b1000, 7'h00, 1'b0, 4'h0, 11'h191, 1'b0}, // R2
    {4'd7,  4'b1010, 7'h20, 1'b1, 4'h5, 11'h1A0, 1'b0}, // R7 old bank used
    {4'd2,  4'b1000, 7'h00, 1'b0, 4'h0, 11'h1A1, 1'b0}, // R2
    {4'd8,  4'b1001, 7'h00, 1'b0, 4'h0, 11'h192, 1'b0}, // R8
    {4'd8,  4'b1010, 7'h01, 1'b0, 4'h0, 11'h281, 1'b0}, // R8 call legal again
    {4'd9,  4'b1010, 7'h02, 1'b0, 4'h0, 11'h282, 1'b1}, // R9 nested
    {4'd9,  4'b1001, 7'h00, 1'b0, 4'h0, 11'h193, 1'b1}, // R9 save kept
    {4'd10, 4'b1111, 7'h7F, 1'b0, 4'h0, 11'h193, 1'b1}, // R10 return wins
    {4'd10, 4'b1110, 7'h7F, 1'b0, 4'h0, 11'h2FF, 1'b1}, // R10 call over jump
    {4'd10, 4'b1001, 7'h00, 1'b0, 4'h0, 11'h194, 1'b1}, // R10 call did save
    {4'd5,  4'b1100, 7'h7F, 1'b1, 4'hF, 11'h2FF, 1'b1}, // R5 same-cycle write
    {4'd5,  4'b1100, 7'h7F, 1'b0, 4'h0, 11'h7FF, 1'b1}, // R5 new bank
    {4'd3,  4'b1000, 7'h00, 1'b0, 4'h0, 11'h000, 1'b1}  // R3 wrap
  };

  task automatic check(input int req, input logic [10:0] ea, input logic ee);
    n_vec++;
    if (fetch_addr !== ea || nest_err !== ee) begin
      n_bad++;
      $display("FAIL R%0d: addr=%h err=%b expected addr=%h err=%b",
               req, fetch_addr, nest_err, ea, ee);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check(1, 11'h000, 1'b0); // R1 reset state
    for (int i = 0; i < NV; i++) begin
      {step, jmp_req, call_req, ret_req} = VECS[i][27:24];
      tgt_ofs    = VECS[i][23:17];
      bank_we    = VECS[i][16];
      bank_wdata = VECS[i][15:12];
      @(negedge clk);
      check(int'(VECS[i][31:28]), VECS[i][11:1], VECS[i][0]);
    end
    // R1: reset mid-run clears address and sticky flag
    {step, jmp_req, call_req, ret_req} = 4'b0000; bank_we = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check(1, 11'h000, 1'b0);
    // R1: bank cleared by reset, jump lands in block 0
    step = 1'b1; jmp_req = 1'b1; tgt_ofs = 7'h44;
    @(negedge clk);
    check(1, 11'h044, 1'b0);
    // R8 with R1: return with no call loads cleared return register
    jmp_req = 1'b0; ret_req = 1'b1;
    @(negedge clk);
    check(8, 11'h000, 1'b0);
    step = 1'b0; ret_req = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #100000;
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule